// File: doc/BRIEF.md
# DMA Transfer Width Packing Engine

This block runs one minor loop of a DMA transfer. It starts from a source access size, a destination access size, a byte count and two start addresses. It then drives source reads and destination writes onto a two-stage pipelined master port. The address phase of one access may overlap the data phase of the access before it.

Bytes that arrive from reads enter a 16-byte staging buffer. When they leave the buffer they are moved onto the byte lanes of each write. This lets the engine pack narrow reads into a wide write, or split one wide read into several narrow writes.

The master port works by handshake. An address phase is offered with `m_avalid` and is accepted on any clock edge where no data phase is pending or `m_ready` is high. A pending data phase completes on the edge where `m_ready` is high. While `m_ready` is low, nothing in the pipeline moves, and the offered address phase and the write data stay where they are. The control pins `start`, `busy` and `done` are plain levels.

Top module: `xpe_engine`

## Requirements
- R1: The size codes 0, 1 and 2 select 1, 2 and 4 bytes. A loop of N bytes issues exactly N/source-bytes reads and N/destination-bytes writes. N is a multiple of the larger size, and each start address is aligned to its own size.
- R2: When the two sizes are equal, the accesses strictly alternate: read, write, read, write, and so on.
- R3: When the source is narrower, each write is preceded by a group of ratio reads. For example, a 16-bit source and a 32-bit destination give read, read, write, repeated.
- R4: When the source is wider, each read is followed by ratio writes. Those writes take the read's bytes in ascending address order, so the low halfword is written first.
- R5: Addresses advance by the access size on each side, starting from the given start addresses. The bus is 32-bit little-endian: the byte at address a uses lane a[1:0]. Destination byte i receives source byte i, and no byte past the count is written.
- R6: With `m_ready` held high, the pipeline never idles. `done` rises exactly (reads + writes + 1) clock edges after the edge that samples `start`.
- R7: While a data phase is pending with `m_ready` low, the offered address phase (`m_avalid`, `m_addr`, `m_write`, `m_size`) and `m_wdata` stay unchanged.
- R8: After reset, `done`, `busy` and `m_avalid` are low. `start` clears `done`. `done` rises when the last write's data phase completes. A byte count of zero sets `done` one edge after `start` and issues no access.
- R9: A `start` sampled while `busy` is high is ignored, and the running loop is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a loop when idle |
| src_size | input | 2 | Source access size code |
| dst_size | input | 2 | Destination access size code |
| byte_count | input | CNT_W (16) | Bytes to move in this loop |
| src_addr | input | ADDR_W (32) | First source address |
| dst_addr | input | ADDR_W (32) | First destination address |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Loop completed, held until next start |
| m_avalid | output | 1 | Address phase offered |
| m_write | output | 1 | Offered access is a write |
| m_addr | output | ADDR_W (32) | Offered access address |
| m_size | output | 2 | Offered access size code |
| m_wdata | output | 32 | Write data during a write data phase |
| m_rdata | input | 32 | Read data during a read data phase |
| m_ready | input | 1 | Data phase completes this edge |

## Verification
Some properties are checked on every cycle: that nothing moves while `m_ready` is low, that the staging buffer never overflows, that it never pops bytes it has not yet been given, and that `done` and `busy` stay consistent. Other behaviour can only be shown by the bench's scenarios. These are the read/write ordering for each size pairing, the byte-exact destination contents with lane placement, the exact completion latency without stalls, and the handling of a zero count or of a `start` that arrives during a loop.

// File: rtl/xpe_pkg.sv
package xpe_pkg;
  localparam int BUS_BYTES = 4;
  localparam int LANE_W    = $clog2(BUS_BYTES);
  localparam int NB_W      = LANE_W + 1;

  typedef struct packed {
    logic              write;
    logic [LANE_W-1:0] lane;
    logic [NB_W-1:0]   nbytes;
  } xpe_dphase_t;

  function automatic logic [NB_W-1:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = NB_W'(1);
      2'd1:    size_bytes = NB_W'(2);
      default: size_bytes = NB_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/xpe_stage.sv
// Byte-wide circular staging buffer; BUF_BYTES must be a power of two.
module xpe_stage import xpe_pkg::*; #(
  parameter int BUF_BYTES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [NB_W-1:0]            push_n,
  input  logic [LANE_W-1:0]          push_lane,
  input  logic [8*BUS_BYTES-1:0]     rdata,
  input  logic                       pop,
  input  logic [NB_W-1:0]            pop_n,
  input  logic [LANE_W-1:0]          pop_lane,
  output logic [8*BUS_BYTES-1:0]     wdata,
  output logic [$clog2(BUF_BYTES):0] level
);
  localparam int PTR_W = $clog2(BUF_BYTES);
  localparam int LVL_W = PTR_W + 1;

  logic [7:0]       mem [BUF_BYTES];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (push) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (k < int'(push_n))
          mem[wptr_q + PTR_W'(k)] <= rdata[8*int'(push_lane + LANE_W'(k)) +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + PTR_W'(push_n);
      if (pop)  rptr_q <= rptr_q + PTR_W'(pop_n);
      level_q <= level_q + (push ? LVL_W'(push_n) : '0) - (pop ? LVL_W'(pop_n) : '0);
    end
  end

  // Place the oldest bytes onto the lanes starting at the write's lane.
  always_comb begin
    logic [LANE_W-1:0] off;
    wdata = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      off = LANE_W'(j) - pop_lane;
      if ({1'b0, off} < pop_n)
        wdata[8*j +: 8] = mem[rptr_q + PTR_W'(off)];
    end
  end

  assign level = level_q;
endmodule

// File: rtl/xpe_seq.sv
// Chooses the next access: a write once enough read bytes are promised,
// otherwise a read while the staging buffer has room reserved for it.
module xpe_seq import xpe_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        src_size,
  input  logic [1:0]        dst_size,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              adv,
  input  logic              wr_retire,
  output logic              busy,
  output logic              done,
  output logic              avalid,
  output logic              awrite,
  output logic [ADDR_W-1:0] aaddr,
  output logic [1:0]        asize,
  output logic [NB_W-1:0]   anbytes
);
  localparam int OCC_W = $clog2(BUF_BYTES) + 2;

  logic              active_q, done_q;
  logic [1:0]        ssz_q, dsz_q;
  logic [CNT_W-1:0]  rd_left_q, wi_left_q, wd_left_q;
  logic [ADDR_W-1:0] sptr_q, dptr_q;
  logic [OCC_W-1:0]  credit_q, resv_q, resv_d;
  logic [NB_W-1:0]   sb, db;
  logic              can_wr, can_rd, take_rd, take_wr;

  assign sb = size_bytes(ssz_q);
  assign db = size_bytes(dsz_q);

  assign can_wr = active_q && (wi_left_q != '0) && (credit_q >= OCC_W'(db));
  assign can_rd = active_q && (rd_left_q != '0) &&
                  ((resv_q + OCC_W'(sb)) <= OCC_W'(BUF_BYTES));

  assign avalid  = can_wr || can_rd;
  assign awrite  = can_wr;
  assign aaddr   = can_wr ? dptr_q : sptr_q;
  assign asize   = can_wr ? dsz_q : ssz_q;
  assign anbytes = can_wr ? db : sb;

  assign take_wr = can_wr && adv;
  assign take_rd = can_rd && !can_wr && adv;

  assign resv_d = resv_q + (take_rd ? OCC_W'(sb) : '0) - (wr_retire ? OCC_W'(db) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      ssz_q     <= '0;
      dsz_q     <= '0;
      rd_left_q <= '0;
      wi_left_q <= '0;
      wd_left_q <= '0;
      sptr_q    <= '0;
      dptr_q    <= '0;
      credit_q  <= '0;
      resv_q    <= '0;
    end else if (!active_q) begin
      if (start) begin
        ssz_q     <= src_size;
        dsz_q     <= dst_size;
        rd_left_q <= byte_count;
        wi_left_q <= byte_count;
        wd_left_q <= byte_count;
        sptr_q    <= src_addr;
        dptr_q    <= dst_addr;
        credit_q  <= '0;
        resv_q    <= '0;
        active_q  <= (byte_count != '0);
        done_q    <= (byte_count == '0);
      end
    end else begin
      resv_q <= resv_d;
      if (take_wr) begin
        wi_left_q <= wi_left_q - CNT_W'(db);
        dptr_q    <= dptr_q + ADDR_W'(db);
        credit_q  <= credit_q - OCC_W'(db);
      end
      if (take_rd) begin
        rd_left_q <= rd_left_q - CNT_W'(sb);
        sptr_q    <= sptr_q + ADDR_W'(sb);
        credit_q  <= credit_q + OCC_W'(sb);
      end
      if (wr_retire) begin
        wd_left_q <= wd_left_q - CNT_W'(db);
        if (wd_left_q == CNT_W'(db)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  assign busy = active_q;
  assign done = done_q;
endmodule

// File: rtl/xpe_engine.sv
module xpe_engine import xpe_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             src_size,
  input  logic [1:0]             dst_size,
  input  logic [CNT_W-1:0]       byte_count,
  input  logic [ADDR_W-1:0]      src_addr,
  input  logic [ADDR_W-1:0]      dst_addr,
  output logic                   busy,
  output logic                   done,
  output logic                   m_avalid,
  output logic                   m_write,
  output logic [ADDR_W-1:0]      m_addr,
  output logic [1:0]             m_size,
  output logic [8*BUS_BYTES-1:0] m_wdata,
  input  logic [8*BUS_BYTES-1:0] m_rdata,
  input  logic                   m_ready
);
  logic                       avalid, awrite;
  logic [ADDR_W-1:0]          aaddr;
  logic [1:0]                 asize;
  logic [NB_W-1:0]            anb;
  logic                       adv, rd_done, wr_done;
  logic                       dp_valid_q;
  xpe_dphase_t                dp_q;
  logic [8*BUS_BYTES-1:0]     stage_wdata;
  logic [$clog2(BUF_BYTES):0] stage_level;

  // Stage 1 / stage 2 hand-off: the address phase moves on when stage 2 frees.
  assign adv     = !dp_valid_q || m_ready;
  assign rd_done = dp_valid_q && !dp_q.write && m_ready;
  assign wr_done = dp_valid_q && dp_q.write && m_ready;

  xpe_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .src_size   (src_size),
    .dst_size   (dst_size),
    .byte_count (byte_count),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .adv        (adv),
    .wr_retire  (wr_done),
    .busy       (busy),
    .done       (done),
    .avalid     (avalid),
    .awrite     (awrite),
    .aaddr      (aaddr),
    .asize      (asize),
    .anbytes    (anb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid_q <= 1'b0;
      dp_q       <= '0;
    end else if (adv) begin
      dp_valid_q  <= avalid;
      dp_q.write  <= awrite;
      dp_q.lane   <= aaddr[LANE_W-1:0];
      dp_q.nbytes <= anb;
    end
  end

  xpe_stage #(.BUF_BYTES(BUF_BYTES)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rd_done),
    .push_n    (dp_q.nbytes),
    .push_lane (dp_q.lane),
    .rdata     (m_rdata),
    .pop       (wr_done),
    .pop_n     (dp_q.nbytes),
    .pop_lane  (dp_q.lane),
    .wdata     (stage_wdata),
    .level     (stage_level)
  );

  assign m_avalid = avalid;
  assign m_write  = awrite;
  assign m_addr   = aaddr;
  assign m_size   = asize;
  assign m_wdata  = (dp_valid_q && dp_q.write) ? stage_wdata : '0;
endmodule

// File: rtl/xpe_checker.sv
module xpe_checker import xpe_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       m_avalid,
  input logic                       m_write,
  input logic [ADDR_W-1:0]          m_addr,
  input logic [1:0]                 m_size,
  input logic [8*BUS_BYTES-1:0]     m_wdata,
  input logic                       m_ready,
  input logic                       dp_valid,
  input logic                       dp_write,
  input logic                       push,
  input logic [NB_W-1:0]            push_n,
  input logic                       pop,
  input logic [NB_W-1:0]            pop_n,
  input logic [$clog2(BUF_BYTES):0] level
);
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !m_ready && m_avalid) |=>
      (m_avalid && $stable(m_addr) && $stable(m_write) && $stable(m_size)));

  a_r7_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_write && !m_ready) |=> $stable(m_wdata));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(level) + int'(push_n) <= BUF_BYTES));

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (int'(level) >= int'(pop_n)));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_avalid);

  a_r1_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    m_avalid |-> (m_size != 2'd3));

  a_r9_busy_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(dp_valid && dp_write && m_ready)) |=> busy);
endmodule

bind xpe_engine xpe_checker #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .m_avalid (m_avalid),
  .m_write  (m_write),
  .m_addr   (m_addr),
  .m_size   (m_size),
  .m_wdata  (m_wdata),
  .m_ready  (m_ready),
  .dp_valid (dp_valid_q),
  .dp_write (dp_q.write),
  .push     (rd_done),
  .push_n   (dp_q.nbytes),
  .pop      (wr_done),
  .pop_n    (dp_q.nbytes),
  .level    (stage_level)
);

// File: tb/xpe_engine_tb_top.sv
`timescale 1ns/1ps
module xpe_engine_tb_top;
  localparam logic [31:0] SRC_BASE = 32'h0000_1000;
  localparam logic [31:0] DST_BASE = 32'h0000_8000;

  typedef struct packed {
    int ss; int ds; int cnt; int soff; int doff; int stl;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{0, 0,  5, 3, 1, 0},
    '{1, 1,  8, 2, 6, 0},
    '{2, 2, 16, 4, 8, 1},
    '{1, 2,  8, 2, 4, 0},
    '{2, 1,  8, 0, 2, 0},
    '{0, 2,  8, 1, 4, 2},
    '{2, 0,  8, 4, 3, 1},
    '{0, 1,  6, 5, 2, 2},
    '{1, 0,  4, 2, 7, 0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  src_size = '0, dst_size = '0;
  logic [15:0] byte_count = '0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic        busy, done, m_avalid, m_write;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic [31:0] m_rdata = '0;
  logic        m_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xpe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_size(src_size), .dst_size(dst_size),
    .byte_count(byte_count), .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy),
    .done(done), .m_avalid(m_avalid), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
  );

  function automatic logic [7:0] src_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // ---------------- bus slave model, evaluated mid-cycle ----------------
  logic [7:0]  dmem [512] = '{default: 8'h00};
  logic        op_w [1024];
  logic [31:0] op_a [1024];
  int          nops = 0;
  int          hold_err = 0;
  int          stall_mode = 0;
  int          scyc = 0;
  logic        sdp_v = 1'b0, sdp_w = 1'b0;
  logic [31:0] sdp_a = '0;
  int          sdp_n = 0;
  logic        held_v = 1'b0, held_w = 1'b0;
  logic [31:0] held_a = '0;

  always @(negedge clk) begin
    logic rdy;
    logic [31:0] word;
    scyc++;
    case (stall_mode)
      1:       rdy = (scyc % 3) != 0;
      2:       rdy = ((scyc / 2) % 2) == 0;
      default: rdy = 1'b1;
    endcase
    if (!rst_n) begin
      sdp_v = 1'b0;
      held_v = 1'b0;
      m_ready = 1'b1;
      m_rdata = '0;
    end else begin
      m_ready = rdy;
      word = '0;
      for (int j = 0; j < 4; j++) word[8*j +: 8] = src_byte({sdp_a[31:2], 2'(j)});
      m_rdata = (sdp_v && !sdp_w) ? word : 32'h0;
      if (held_v && !(m_avalid && m_addr == held_a && m_write == held_w)) hold_err++;
      held_v = 1'b0;
      if (sdp_v && rdy && sdp_w) begin
        for (int k = 0; k < sdp_n; k++)
          dmem[9'(sdp_a - DST_BASE + 32'(k))] = m_wdata[8*((int'(sdp_a[1:0]) + k) % 4) +: 8];
      end
      if (sdp_v && !rdy && m_avalid) begin
        held_v = 1'b1;
        held_a = m_addr;
        held_w = m_write;
      end
      if (!sdp_v || rdy) begin
        if (m_avalid) begin
          if (nops < 1024) begin
            op_w[nops] = m_write;
            op_a[nops] = m_addr;
          end
          nops++;
          sdp_v = 1'b1;
          sdp_w = m_write;
          sdp_a = m_addr;
          sdp_n = 1 << m_size;
        end else begin
          sdp_v = 1'b0;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input int ss, input int ds, input int cnt, input int soff,
                         input int doff, input int stl, input int region, input int restart_at);
    int sb, db, base, hbase, cyc, nr, nw, ne, big, ratio, seq_bad, dbad, tail_bad;
    int ri, wi;
    logic [31:0] sa, da;
    logic        exp_w [64];
    logic [31:0] exp_a [64];
    string       seq_req;
    sb = 1 << ss;
    db = 1 << ds;
    sa = SRC_BASE + 32'(soff);
    da = DST_BASE + 32'(region * 32 + doff);
    @(negedge clk);
    stall_mode = stl;
    src_size = 2'(ss);
    dst_size = 2'(ds);
    byte_count = 16'(cnt);
    src_addr = sa;
    dst_addr = da;
    start = 1'b1;
    base = nops;
    hbase = hold_err;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 600) begin
      @(negedge clk);
      cyc++;
      if (restart_at != 0 && cyc == restart_at) begin
        // R9: a second start with other settings while busy
        src_size = 2'd0; dst_size = 2'd0; byte_count = 16'd2;
        src_addr = 32'h0; dst_addr = DST_BASE; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(done == 1'b1, "R8", "done reached", done, 1);
    check(busy == 1'b0, "R8", "busy low at end", busy, 0);
    nr = 0; nw = 0;
    for (int i = base; i < nops; i++) if (op_w[i]) nw++; else nr++;
    check(nr == cnt / sb, "R1", "read count", nr, cnt / sb);
    check(nw == cnt / db, "R1", "write count", nw, cnt / db);
    // expected order and addresses
    ne = 0; ri = 0; wi = 0;
    big = (sb > db) ? sb : db;
    ratio = (sb > db) ? sb / db : db / sb;
    for (int g = 0; g < cnt / big; g++) begin
      if (sb <= db) begin
        for (int r = 0; r < ratio; r++) begin
          exp_w[ne] = 1'b0; exp_a[ne] = sa + 32'(ri * sb); ne++; ri++;
        end
        exp_w[ne] = 1'b1; exp_a[ne] = da + 32'(wi * db); ne++; wi++;
      end else begin
        exp_w[ne] = 1'b0; exp_a[ne] = sa + 32'(ri * sb); ne++; ri++;
        for (int r = 0; r < ratio; r++) begin
          exp_w[ne] = 1'b1; exp_a[ne] = da + 32'(wi * db); ne++; wi++;
        end
      end
    end
    seq_req = (sb == db) ? "R2" : ((sb < db) ? "R3" : "R4");
    seq_bad = (nops - base != ne) ? 1 : 0;
    for (int i = 0; i < ne && i < nops - base; i++)
      if (op_w[base + i] != exp_w[i] || op_a[base + i] != exp_a[i]) seq_bad++;
    check(seq_bad == 0, seq_req, "access order/address mismatches", seq_bad, 0);
    dbad = 0;
    for (int i = 0; i < cnt; i++)
      if (dmem[9'(region * 32 + doff + i)] != src_byte(sa + 32'(i))) dbad++;
    check(dbad == 0, "R5", "destination byte mismatches", dbad, 0);
    tail_bad = 0;
    for (int i = 0; i < 4; i++)
      if (dmem[9'(region * 32 + doff + cnt + i)] != 8'h00) tail_bad++;
    check(tail_bad == 0, "R5", "bytes written past count", tail_bad, 0);
    if (stl == 0)
      check(cyc == nr + nw + 1, "R6", "edges from start to done", cyc, nr + nw + 1);
    else
      check(hold_err == hbase, "R7", "address phase changed under stall", hold_err - hbase, 0);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    do_reset();
    // R8: reset state
    check(done == 1'b0, "R8", "done after reset", done, 0);
    check(busy == 1'b0, "R8", "busy after reset", busy, 0);
    check(m_avalid == 1'b0, "R8", "m_avalid after reset", m_avalid, 0);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v].ss, VECS[v].ds, VECS[v].cnt, VECS[v].soff,
              VECS[v].doff, VECS[v].stl, v, 0);

    // R9: start pulse during a running loop is ignored
    run_vec(1, 2, 8, 2, 4, 0, 10, 3);

    // R8: zero byte count
    do_reset();
    begin
      int b0;
      b0 = nops;
      src_size = 2'd2; dst_size = 2'd2; byte_count = 16'd0;
      src_addr = SRC_BASE; dst_addr = DST_BASE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R8", "done one edge after zero-count start", done, 1);
      check(busy == 1'b0, "R8", "busy for zero count", busy, 0);
      repeat (4) @(negedge clk);
      check(nops == b0, "R8", "accesses for zero count", nops - b0, 0);
    end

    // R8: start clears done
    byte_count = 16'd4; src_size = 2'd1; dst_size = 2'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R8", "done cleared by start", done, 0);
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: run did not complete, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule